// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and an asynchronous 128K x 8 static RAM. It takes one read or write request at a time from the host and produces the active-low chip-select, output-enable and write-strobe sequence the memory needs. It also drives the memory address bus and the outgoing half of a split data bus (value plus drive enable), and it samples the returned read word. Every phase length is a whole number of clock cycles, set by a parameter. The integrator picks these counts so that each nanosecond minimum of the memory, rounded up to whole cycles, is met.

A host raises `req_valid` with the address, direction and write data. The request is taken on the first clock edge where `req_ready` is high. The sequencer then walks a fixed state path:
- Read: S_IDLE -> S_RD_SETUP -> S_RD_WAIT -> S_RD_CAPTURE -> S_TURN -> S_IDLE.
- Write: S_IDLE -> S_WR_SETUP -> S_WR_PULSE -> S_WR_RECOVER -> S_IDLE.

The phase-timed states (S_RD_SETUP, S_RD_WAIT, S_TURN, S_WR_SETUP, S_WR_PULSE) leave when their phase counter expires. S_RD_CAPTURE and S_WR_RECOVER always last one cycle. The sequencer holds the address and write data in registers for the whole access. It keeps the memory deselected whenever it is idle. After every read it waits out a release interval, so its own data drivers never overlap the memory's.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While idle, and from reset, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, `rd_valid` is 0 and `req_ready` is 1.
- R2: A request is taken at a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is then 0 from the next cycle until the access ends. A request held during that time starts no access until `req_ready` returns.
- R3: A read (`req_write` = 0) first spends SETUP_CYC cycles with `mem_ce_n`=0, `mem_oe_n`=1, `mem_we_n`=1. It then spends RDWAIT_CYC cycles with `mem_ce_n`=0, `mem_oe_n`=0, `mem_we_n`=1.
- R4: `rd_data` takes the value on `mem_dq_in` at the edge that ends the output-enable phase. `rd_valid` is 1 for exactly the one following cycle (strobes all 1 again) and is 0 at all other times.
- R5: After the read-capture cycle come TURN_CYC cycles with all strobes 1 and drivers off. A read therefore keeps `req_ready` low for SETUP_CYC+RDWAIT_CYC+1+TURN_CYC cycles.
- R6: A write (`req_write` = 1) runs these phases, each with `mem_oe_n`=1 and `mem_dq_oe`=1:
  - SETUP_CYC cycles with `mem_ce_n`=0, `mem_we_n`=1;
  - then PULSE_CYC cycles with `mem_we_n`=0;
  - then one cycle with `mem_ce_n`=0, `mem_we_n`=1.
  It then returns to idle, and `req_ready` is low for SETUP_CYC+PULSE_CYC+1 cycles.
- R7: While `mem_ce_n` is 0, `mem_addr` equals the address of the accepted request and does not change. While `mem_dq_oe` is 1, `mem_dq_out` equals the accepted write data.
- R8: `mem_dq_oe` is 1 only during a write. It is never 1 in a cycle where the memory drives (`mem_ce_n`=0, `mem_oe_n`=0, `mem_we_n`=1), nor in the cycle right after the memory stops driving.
- R9: All 17 address bits pass to `mem_addr` unchanged, including address 0 and address 0x1FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Sequencer idle, request may be taken |
| rd_data | output | 8 | Captured read word |
| rd_valid | output | 1 | One-cycle strobe marking `rd_data` |
| mem_addr | output | 17 | Memory address bus |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_in | input | 8 | Data returned by the memory |
| mem_dq_oe | output | 1 | Enable for the outgoing data drivers |

## Verification
The end of one access and the acceptance of the next can fall in the same cycle. A request is held on `req_valid` while the previous access finishes, so the return of `req_ready` and the start of a new phase sequence meet. This matters most when a write follows a read and the bus has to change direction. The bench drives alternating write/read pairs back to back in this way and compares every strobe, the address, the data drivers and `rd_data` against a per-cycle reference schedule. A memory model that follows the chip-select/output-enable/write-strobe truth table flags any cycle in which both sides drive the data bus, including the release cycle.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_SETUP,
        S_RD_WAIT,
        S_RD_CAPTURE,
        S_TURN,
        S_WR_SETUP,
        S_WR_PULSE,
        S_WR_RECOVER
    } seq_state_t;

endpackage

// File: rtl/sram_phase_timer.sv
// Down-counter that times one phase; reloaded on every state change.
module sram_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sram_req_hold.sv
// Holds address and write data of the accepted request for the whole access.
module sram_req_hold #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (take) begin
            addr_q <= addr_in;
            data_q <= data_in;
        end
    end
endmodule

// File: rtl/sram_rd_capture.sv
// Samples the returned word and raises a one-cycle valid strobe.
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= cap_en;
            if (cap_en)
                rd_data <= dq_in;
        end
    end
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int DATA_W     = 8,
    parameter int SETUP_CYC  = 1,
    parameter int PULSE_CYC  = 2,
    parameter int RDWAIT_CYC = 2,
    parameter int TURN_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);
    localparam int MAX_A   = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int MAX_B   = (RDWAIT_CYC > TURN_CYC) ? RDWAIT_CYC : TURN_CYC;
    localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    seq_state_t       state, nxt;
    logic             ph_done, ph_load, take, cap_en;
    logic [CNT_W-1:0] ph_len;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt    = state;
        take   = 1'b0;
        cap_en = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (req_valid) begin
                    take = 1'b1;
                    nxt  = req_write ? S_WR_SETUP : S_RD_SETUP;
                end
            end
            S_RD_SETUP:   if (ph_done) nxt = S_RD_WAIT;
            S_RD_WAIT: begin
                if (ph_done) begin
                    cap_en = 1'b1;
                    nxt    = S_RD_CAPTURE;
                end
            end
            S_RD_CAPTURE: nxt = S_TURN;
            S_TURN:       if (ph_done) nxt = S_IDLE;
            S_WR_SETUP:   if (ph_done) nxt = S_WR_PULSE;
            S_WR_PULSE:   if (ph_done) nxt = S_WR_RECOVER;
            S_WR_RECOVER: nxt = S_IDLE;
            default:      nxt = S_IDLE;
        endcase
    end

    // Phase length of the state being entered
    assign ph_load = (nxt != state);
    always_comb begin
        unique case (nxt)
            S_RD_SETUP, S_WR_SETUP: ph_len = CNT_W'(SETUP_CYC - 1);
            S_RD_WAIT:              ph_len = CNT_W'(RDWAIT_CYC - 1);
            S_WR_PULSE:             ph_len = CNT_W'(PULSE_CYC - 1);
            S_TURN:                 ph_len = CNT_W'(TURN_CYC - 1);
            default:                ph_len = '0;
        endcase
    end

    // Strobes decoded from the state register
    always_comb begin
        req_ready = 1'b0;
        mem_ce_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_dq_oe = 1'b0;
        unique case (state)
            S_IDLE:       req_ready = 1'b1;
            S_RD_SETUP:   mem_ce_n  = 1'b0;
            S_RD_WAIT: begin
                mem_ce_n = 1'b0;
                mem_oe_n = 1'b0;
            end
            S_RD_CAPTURE, S_TURN: ;
            S_WR_SETUP, S_WR_RECOVER: begin
                mem_ce_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            S_WR_PULSE: begin
                mem_ce_n  = 1'b0;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            default: ;
        endcase
    end

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_len),
        .done     (ph_done)
    );

    sram_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .addr_in (req_addr),
        .data_in (req_wdata),
        .addr_q  (mem_addr),
        .data_q  (mem_dq_out)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .dq_in    (mem_dq_in),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );
endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rd_valid));

    a_r3_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n));

    a_r4_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    a_r4_valid_after_oe: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(!mem_oe_n) && mem_oe_n));

    a_r5_turn_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !req_ready);

    a_r6_we_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_dq_oe));

    a_r6_we_rise_held: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe));

    a_r7_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    a_r7_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

    a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && $past(mem_oe_n)));
endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_seq_ctrl_bench.sv
`timescale 1ns/1ps
module sram_seq_ctrl_bench;
    localparam int S_C = 2;
    localparam int P_C = 3;
    localparam int R_C = 2;
    localparam int T_C = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rd_valid;
    logic [7:0]  rd_data;
    logic [16:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'h3C;

    always #4 clk = ~clk;  // 125 MHz

    sram_seq_ctrl #(
        .SETUP_CYC(S_C), .PULSE_CYC(P_C), .RDWAIT_CYC(R_C), .TURN_CYC(T_C)
    ) u_sram_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    int n_tests = 0, n_fail = 0;
    bit run = 1'b0, finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Initial memory content, a function of the address
    function automatic logic [7:0] init_pat(input logic [16:0] a);
        return a[7:0] ^ a[15:8] ^ {7'b0, a[16]};
    endfunction

    // ---------------- memory model (truth table) ----------------
    logic [7:0] mem_arr [int];
    logic [7:0] ref_arr [int];
    bit mem_drv = 1'b0, mem_drv_q = 1'b0;

    always @(posedge mem_we_n)
        if (run && !mem_ce_n) begin
            chk(mem_dq_oe, "R6", "data driven at write end", {31'b0, mem_dq_oe}, 1);
            mem_arr[int'(mem_addr)] = mem_dq_out;
        end
    always @(posedge mem_ce_n)
        if (run && !mem_we_n) mem_arr[int'(mem_addr)] = mem_dq_out;

    always @(negedge clk) begin
        mem_drv_q = mem_drv;
        mem_drv   = run && !mem_ce_n && !mem_oe_n && mem_we_n;
        if (mem_drv)
            mem_dq_in = mem_arr.exists(int'(mem_addr)) ? mem_arr[int'(mem_addr)] : init_pat(mem_addr);
        else
            mem_dq_in = 8'h3C;
        // R8: no overlap, including the release cycle after the memory stops driving
        if (run && mem_dq_oe && (mem_drv || mem_drv_q))
            chk(1'b0, "R8", "bus overlap", 1, 0);
    end

    // ---------------- per-cycle reference schedule ----------------
    typedef struct {
        bit rdy, ce, oe, we, doe, val, ca, cd, cr;
        logic [16:0] a;
        logic [7:0]  d;
        int tag;
    } exp_t;
    exp_t expq[$];
    exp_t e;
    int we_run = 0, we_pulses = 0, rd_pulses = 0, n_wr = 0, n_rd = 0, cyc = 0;

    function automatic void push_e(bit ce, bit oe, bit we, bit doe, bit val,
                                   bit ca, bit cd, bit cr,
                                   logic [16:0] a, logic [7:0] d, int tag);
        exp_t x;
        x.rdy = 1'b0; x.ce = ce; x.oe = oe; x.we = we; x.doe = doe; x.val = val;
        x.ca = ca; x.cd = cd; x.cr = cr; x.a = a; x.d = d; x.tag = tag;
        expq.push_back(x);
    endfunction

    function automatic void schedule(bit wr, logic [16:0] a, logic [7:0] d);
        logic [7:0] rv;
        if (wr) begin
            ref_arr[int'(a)] = d;
            n_wr++;
            for (int i = 0; i < S_C; i++) push_e(0, 1, 1, 1, 0, 1, 1, 0, a, d, 6); // R6
            for (int i = 0; i < P_C; i++) push_e(0, 1, 0, 1, 0, 1, 1, 0, a, d, 6);
            push_e(0, 1, 1, 1, 0, 1, 1, 0, a, d, 6);
        end else begin
            rv = ref_arr.exists(int'(a)) ? ref_arr[int'(a)] : init_pat(a);
            n_rd++;
            for (int i = 0; i < S_C; i++) push_e(0, 1, 1, 0, 0, 1, 0, 0, a, 0, 3); // R3
            for (int i = 0; i < R_C; i++) push_e(0, 0, 1, 0, 0, 1, 0, 0, a, 0, 3);
            push_e(1, 1, 1, 0, 1, 0, 0, 1, a, rv, 4);                             // R4
            for (int i = 0; i < T_C; i++) push_e(1, 1, 1, 0, 0, 0, 0, 0, a, 0, 5); // R5
        end
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
            summary();
        end
        if (run) begin
            if (expq.size() > 0) e = expq.pop_front();
            else begin
                e.rdy = 1; e.ce = 1; e.oe = 1; e.we = 1; e.doe = 0; e.val = 0;
                e.ca = 0; e.cd = 0; e.cr = 0; e.tag = 1;   // R1 idle
            end
            chk(req_ready == e.rdy, "R2", "req_ready", {31'b0, req_ready}, {31'b0, e.rdy});
            chk({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe} == {e.ce, e.oe, e.we, e.doe},
                $sformatf("R%0d", e.tag), "strobes ce/oe/we/doe",
                {28'b0, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe},
                {28'b0, e.ce, e.oe, e.we, e.doe});
            chk(rd_valid == e.val, "R4", "rd_valid", {31'b0, rd_valid}, {31'b0, e.val});
            if (e.ca)
                chk(mem_addr == e.a, (e.a == 17'h0 || e.a == 17'h1FFFF) ? "R9" : "R7",
                    "mem_addr", {15'b0, mem_addr}, {15'b0, e.a});
            if (e.cd)
                chk(mem_dq_out == e.d, "R7", "mem_dq_out", {24'b0, mem_dq_out}, {24'b0, e.d});
            if (e.cr)
                chk(rd_data == e.d, "R4", "rd_data", {24'b0, rd_data}, {24'b0, e.d});
            // WE pulse width monitor (R6)
            if (!mem_we_n) we_run++;
            else if (we_run > 0) begin
                chk(we_run == P_C, "R6", "write strobe width", we_run, P_C);
                we_run = 0;
                we_pulses++;
            end
            if (rd_valid) rd_pulses++;
            // request taken at the coming edge
            if (req_valid && req_ready) schedule(req_write, req_addr, req_wdata);
        end
    end

    // ---------------- stimulus ----------------
    task automatic access(input bit wr, input logic [16:0] a, input logic [7:0] d);
        req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
        while (1) begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk); #2;
        req_valid = 1'b0;
        req_addr  = ~a;   // change inputs after acceptance (R7)
        req_wdata = ~d;
    endtask

    task automatic busy_len(input bit wr, input logic [16:0] a, input int exp_len, input string tag);
        int n = 0;
        access(wr, a, 8'h96);
        while (1) begin
            @(negedge clk);
            if (req_ready) break;
            n++;
        end
        chk(n == exp_len, tag, "busy cycles", n, exp_len);
        @(posedge clk); #2;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rd_valid && req_ready,
            "R1", "reset outputs",
            {26'b0, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rd_valid, req_ready}, 32'h39);
        @(posedge clk); #2;
        rst_n = 1'b1;
        run   = 1'b1;
        repeat (2) @(posedge clk); #2;

        // boundary addresses and data (R9)
        access(1, 17'h00000, 8'h5A);
        access(1, 17'h1FFFF, 8'hFF);
        access(1, 17'h0ABCD, 8'h00);
        access(0, 17'h1FFFF, 8'h00);
        access(0, 17'h00000, 8'h00);
        access(0, 17'h0ABCD, 8'h00);
        // unwritten location returns initial content
        access(0, 17'h12345, 8'h00);

        // back-to-back write/read pairs: turnaround meets next acceptance
        for (int i = 0; i < 8; i++) begin
            access(1, 17'(17'h00100 + i * 37), 8'(i * 29 + 3));
            access(0, 17'(17'h00100 + i * 37), 8'h00);
        end
        // read then write with no gap (R5, R8)
        for (int i = 0; i < 4; i++) begin
            access(0, 17'(17'h1F000 + i), 8'h00);
            access(1, 17'(17'h1F000 + i), 8'(8'hC0 + i));
        end
        for (int i = 0; i < 4; i++) access(0, 17'(17'h1F000 + i), 8'h00);

        // busy length per direction
        while (expq.size() > 0) @(posedge clk);
        #2;
        busy_len(0, 17'h00777, S_C + R_C + 1 + T_C, "R5");
        busy_len(1, 17'h00778, S_C + P_C + 1, "R6");

        repeat (2) @(posedge clk); #2;
        // R2: a request held high across a whole access starts exactly one access
        req_write = 1'b0; req_addr = 17'h00778; req_valid = 1'b1;
        @(posedge clk); #2;
        repeat (S_C + R_C) @(posedge clk);
        #2;
        req_valid = 1'b0;

        while (expq.size() > 0) @(posedge clk);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(rd_pulses == n_rd, "R4", "rd_valid pulse count", rd_pulses, n_rd);
        chk(we_pulses == n_wr, "R6", "write pulse count", we_pulses, n_wr);
        chk(expq.size() == 0 && req_ready, "R2", "idle at end", {31'b0, req_ready}, 1);
        summary();
    end
endmodule